// File: doc/BRIEF.md
# Product-Term Cluster Allocator

This block is the combinational core of a small programmable sum-of-products slice. An array of AND gates builds product terms from a shared input bus. Every input bit is offered to each term as a true literal and as a complemented literal, and each term has its own enable and selection bits. The terms are grouped into one cluster per macrocell. Each cluster has a basic part whose width is set by its home macrocell's timing mode, and one spare term. The spare term either widens the cluster or drives the XOR stage of the home macrocell.

A two-bit steering code sends each cluster to its home macrocell or to a nearby one. Each macrocell ORs every cluster that lands on it and passes the result through an XOR gate. The XOR gate's second input is either the home cluster's spare term or a programmed polarity constant. All programming arrives on static configuration ports. The block produces one combinational output per macrocell.

Top module: `ptc_alloc`

## Requirements
- R1: A product term is the AND of every input bit whose true-select bit is set and the complement of every input bit whose complement-select bit is set. An enabled term with no literal selected is 1.
- R2: A term whose disable bit (`cfg_pt_off`) is 1 contributes 0, whatever its literal selection.
- R3: With `cfg_async[c]`=0 (synchronous), the basic part of cluster c is its slots 0 to 3. Term index is c*5+slot, and slot 4 is the spare.
- R4: With `cfg_async[c]`=1 (asynchronous), the basic part of cluster c is slots 0 and 1 only. Slots 2 and 3 have no effect on any output.
- R5: The basic width of a cluster follows the mode of its home macrocell. The mode of the macrocell it is steered to has no effect on it.
- R6: With `cfg_extend[c]`=1, the spare term joins cluster c's sum, and the XOR second input of macrocell c is the constant `cfg_polarity[c]`.
- R7: With `cfg_extend[c]`=0, the spare term of cluster c is left out of the sum and drives the XOR second input of macrocell c, wherever cluster c is steered.
- R8: Steering code 0 sends cluster c to macrocell c. Code 1 sends it to c+1, code 2 to c-1 and code 3 to c+2, all modulo the macrocell count.
- R9: Each macrocell output is the OR of all clusters steered to it, XORed with its second input. A macrocell that receives no cluster outputs its XOR second input alone.
- R10: With four extended synchronous clusters steered to one macrocell, any one of the 20 terms alone drives it. If the home cluster is asynchronous, only 18 of the terms do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | N_IN | Shared input bus to the AND array |
| cfg_lit_true | input | N_PT x N_IN | Per term: which inputs are used in true form |
| cfg_lit_comp | input | N_PT x N_IN | Per term: which inputs are used in complement form |
| cfg_pt_off | input | N_PT | Per term disable, 1 forces the term to 0 |
| cfg_async | input | N_MC | Per macrocell mode, 1 = asynchronous |
| cfg_extend | input | N_MC | Per cluster: spare term joins the sum (1) or feeds the XOR (0) |
| cfg_polarity | input | N_MC | Per macrocell XOR constant, used when the cluster is extended |
| cfg_steer | input | N_MC x 2 | Per cluster steering code |
| mc_out | output | N_MC | Combinational macrocell outputs |

## Verification
The hardest case to reach from the ports is a cluster steered away from a home macrocell whose mode differs from the destination's, while one of the slot-2 or slot-3 terms is the only true term. Random product terms are mostly false, so random stimulus almost never isolates that term. Directed cases therefore enable a single term that has no literals, set it on a chosen slot, and toggle the home and destination modes one at a time. A random phase with sparse literal masks then covers mixed steering, modes and spare-term uses, with every output compared against a sum-of-products reference model in the bench.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

  // Destination macrocell for a cluster, given its home index and steering code.
  function automatic int unsigned steer_dest(input int unsigned home,
                                             input logic [1:0] code,
                                             input int unsigned n_mc);
    int unsigned step;
    case (code)
      2'd0:    step = 0;
      2'd1:    step = 1;
      2'd2:    step = n_mc - 1;
      default: step = 2;
    endcase
    return (home + step) % n_mc;
  endfunction

  // Number of basic slots in play for a cluster, chosen by its home mode.
  function automatic int unsigned basic_width(input logic async_mode,
                                              input int unsigned sync_w,
                                              input int unsigned async_w);
    return async_mode ? async_w : sync_w;
  endfunction

endpackage

// File: rtl/ptc_term.sv
module ptc_term #(
  parameter int N_IN = 33
) (
  input  logic [N_IN-1:0] din,
  input  logic [N_IN-1:0] sel_t,
  input  logic [N_IN-1:0] sel_c,
  input  logic            off,
  output logic            term
);
  logic [N_IN-1:0] lit_pass;
  always_comb begin
    lit_pass = (din | ~sel_t) & (~din | ~sel_c);
    term     = !off && (&lit_pass);
  end
endmodule

// File: rtl/ptc_cluster.sv
module ptc_cluster
  import ptc_pkg::*;
#(
  parameter int N_IN     = 33,
  parameter int SYNC_PT  = 4,
  parameter int ASYNC_PT = 2
) (
  input  logic [N_IN-1:0]              din,
  input  logic [SYNC_PT:0][N_IN-1:0]   sel_t,
  input  logic [SYNC_PT:0][N_IN-1:0]   sel_c,
  input  logic [SYNC_PT:0]             off,
  input  logic                         async_m,
  input  logic                         extend,
  input  logic                         pol,
  output logic                         sum,
  output logic                         xor_src
);
  localparam int XTRA = SYNC_PT;

  logic [SYNC_PT:0]   term;
  logic [SYNC_PT-1:0] slot_live;

  for (genvar k = 0; k <= SYNC_PT; k++) begin : g_term
    ptc_term #(.N_IN(N_IN)) u_term (
      .din  (din),
      .sel_t(sel_t[k]),
      .sel_c(sel_c[k]),
      .off  (off[k]),
      .term (term[k])
    );
  end

  always_comb begin
    for (int k = 0; k < SYNC_PT; k++)
      slot_live[k] = (k < int'(basic_width(async_m, SYNC_PT, ASYNC_PT)));
    sum     = (|(term[SYNC_PT-1:0] & slot_live)) | (extend & term[XTRA]);
    xor_src = extend ? pol : term[XTRA];
  end

  always_comb begin
    for (int k = 0; k <= SYNC_PT; k++)
      if (off[k]) assert_off_zero_R2: assert (!term[k]);
    if (extend && term[XTRA]) assert_ext_joins_R6: assert (sum);
    if (!extend && term[XTRA] && !(|term[SYNC_PT-1:0]))
      assert_spare_out_R7: assert (!sum && xor_src);
    if (async_m && !(|term[ASYNC_PT-1:0]) && !(extend && term[XTRA]))
      assert_async_narrow_R4: assert (!sum);
  end
endmodule

// File: rtl/ptc_macrocell.sv
module ptc_macrocell #(
  parameter int N_CL = 4
) (
  input  logic [N_CL-1:0] hit,
  input  logic [N_CL-1:0] cl_sum,
  input  logic            xor_in,
  output logic            out
);
  logic gathered;
  always_comb begin
    gathered = |(hit & cl_sum);
    out      = gathered ^ xor_in;
  end

  always_comb begin
    if (!(|hit)) assert_idle_xor_R9: assert (out == xor_in);
  end
endmodule

// File: rtl/ptc_alloc.sv
module ptc_alloc
  import ptc_pkg::*;
#(
  parameter int N_IN     = 33,
  parameter int N_MC     = 4,
  parameter int SYNC_PT  = 4,
  parameter int ASYNC_PT = 2,
  localparam int PT_PER  = SYNC_PT + 1,
  localparam int N_PT    = N_MC * PT_PER
) (
  input  logic [N_IN-1:0]            data_in,
  input  logic [N_PT-1:0][N_IN-1:0]  cfg_lit_true,
  input  logic [N_PT-1:0][N_IN-1:0]  cfg_lit_comp,
  input  logic [N_PT-1:0]            cfg_pt_off,
  input  logic [N_MC-1:0]            cfg_async,
  input  logic [N_MC-1:0]            cfg_extend,
  input  logic [N_MC-1:0]            cfg_polarity,
  input  logic [N_MC-1:0][1:0]       cfg_steer,
  output logic [N_MC-1:0]            mc_out
);
  logic [N_MC-1:0]            cl_sum;
  logic [N_MC-1:0]            xor_src;
  logic [N_MC-1:0][N_MC-1:0]  hit_cm;   // [cluster][macrocell]
  logic [N_MC-1:0][N_MC-1:0]  hit_mc;   // [macrocell][cluster]

  for (genvar c = 0; c < N_MC; c++) begin : g_cl
    ptc_cluster #(.N_IN(N_IN), .SYNC_PT(SYNC_PT), .ASYNC_PT(ASYNC_PT)) u_cl (
      .din    (data_in),
      .sel_t  (cfg_lit_true[c*PT_PER +: PT_PER]),
      .sel_c  (cfg_lit_comp[c*PT_PER +: PT_PER]),
      .off    (cfg_pt_off[c*PT_PER +: PT_PER]),
      .async_m(cfg_async[c]),
      .extend (cfg_extend[c]),
      .pol    (cfg_polarity[c]),
      .sum    (cl_sum[c]),
      .xor_src(xor_src[c])
    );
    for (genvar m = 0; m < N_MC; m++) begin : g_hit
      assign hit_cm[c][m] = (steer_dest(c, cfg_steer[c], N_MC) == m);
      assign hit_mc[m][c] = hit_cm[c][m];
    end
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    ptc_macrocell #(.N_CL(N_MC)) u_mc (
      .hit   (hit_mc[m]),
      .cl_sum(cl_sum),
      .xor_in(xor_src[m]),
      .out   (mc_out[m])
    );
  end

  always_comb begin
    for (int c = 0; c < N_MC; c++)
      assert_dest_onehot_R8: assert ($onehot(hit_cm[c]));
    for (int m = 0; m < N_MC; m++)
      if (|(hit_mc[m] & cl_sum)) assert_or_invert_R9: assert (mc_out[m] == !xor_src[m]);
  end
endmodule

// File: tb/tb_ptc_alloc.sv
`timescale 1ns/1ps
module tb_ptc_alloc;
  localparam int N_IN = 33, N_MC = 4, SYNC_PT = 4, ASYNC_PT = 2;
  localparam int PT_PER = SYNC_PT + 1, N_PT = N_MC * PT_PER;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [N_IN-1:0]           din;
  logic [N_PT-1:0][N_IN-1:0] lt, lc;
  logic [N_PT-1:0]           poff;
  logic [N_MC-1:0]           asy, ext, pol;
  logic [N_MC-1:0][1:0]      st;
  logic [N_MC-1:0]           mc_out;

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;

  ptc_alloc dut (
    .data_in(din), .cfg_lit_true(lt), .cfg_lit_comp(lc), .cfg_pt_off(poff),
    .cfg_async(asy), .cfg_extend(ext), .cfg_polarity(pol), .cfg_steer(st),
    .mc_out(mc_out)
  );

  function automatic bit ref_pt(int idx);
    if (poff[idx]) return 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (lt[idx][i] && !din[i]) return 1'b0;
      if (lc[idx][i] &&  din[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic int ref_dest(int c);
    int off;
    case (st[c])
      2'd0: off = 0;
      2'd1: off = 1;
      2'd2: off = -1;
      default: off = 2;
    endcase
    return (c + off + N_MC) % N_MC;
  endfunction

  function automatic bit ref_mc(int m);
    bit acc = 1'b0, x;
    for (int c = 0; c < N_MC; c++) begin
      if (ref_dest(c) != m) continue;
      for (int k = 0; k < (asy[c] ? ASYNC_PT : SYNC_PT); k++)
        acc |= ref_pt(c*PT_PER + k);
      if (ext[c]) acc |= ref_pt(c*PT_PER + SYNC_PT);
    end
    x = ext[m] ? pol[m] : ref_pt(m*PT_PER + SYNC_PT);
    return acc ^ x;
  endfunction

  function automatic logic [N_IN-1:0] sparse();
    logic [63:0] a;
    a = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
    return a[N_IN-1:0];
  endfunction

  task automatic clear_cfg();
    lt = '0; lc = '0; poff = '1; asy = '0; ext = '0; pol = '0; st = '0; din = '0;
  endtask

  // Compare every output against the reference model.
  task automatic check_all(string tag);
    logic [N_MC-1:0] exp;
    @(negedge clk);
    for (int m = 0; m < N_MC; m++) exp[m] = ref_mc(m);
    vectors++;
    if (mc_out !== exp) begin
      miscompares++;
      $display("FAIL %s: mc_out=%b expected %b", tag, mc_out, exp);
    end
  endtask

  // Compare one output against a hand-derived value.
  task automatic expect_mc(int m, bit exp, string tag);
    @(negedge clk);
    vectors++;
    if (mc_out[m] !== exp) begin
      miscompares++;
      $display("FAIL %s: mc_out[%0d]=%b expected %b", tag, m, mc_out[m], exp);
    end
  endtask

  initial begin
    #800000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    clear_cfg();
    // R2: everything disabled gives all zeros
    @(negedge clk);
    vectors++;
    if (mc_out !== '0) begin
      miscompares++;
      $display("FAIL R2 idle: mc_out=%b expected 0000", mc_out);
    end

    // R1: term0 = in[0] & ~in[1], extended so XOR is polarity 0
    poff[0] = 1'b0; lt[0][0] = 1'b1; lc[0][1] = 1'b1; ext = '1;
    din = 33'b01; expect_mc(0, 1'b1, "R1 true+comp met");
    din = 33'b11; expect_mc(0, 1'b0, "R1 complement blocks");
    din = 33'b00; expect_mc(0, 1'b0, "R1 true blocks");
    lt[0] = '0; lc[0] = '0; din = '1; expect_mc(0, 1'b1, "R1 no literal");
    poff[0] = 1'b1; expect_mc(0, 1'b0, "R2 disabled");

    // R3/R4/R5: slot 2 of cluster 0 alone, steered to macrocell 1
    clear_cfg(); ext = '1; poff[2] = 1'b0; st[0] = 2'd1;
    asy[0] = 1'b0; asy[1] = 1'b1; expect_mc(1, 1'b1, "R3 sync home slot2 (R5 dest async)");
    asy[0] = 1'b1; asy[1] = 1'b0; expect_mc(1, 1'b0, "R4 async home slot2 ignored (R5)");
    poff[2] = 1'b1; poff[3] = 1'b0; expect_mc(1, 1'b0, "R4 async home slot3 ignored");
    asy[0] = 1'b0; expect_mc(1, 1'b1, "R3 sync home slot3");

    // R6/R7: spare term of cluster 0, cluster steered to macrocell 2
    clear_cfg(); poff[SYNC_PT] = 1'b0; st[0] = 2'd3;
    ext[0] = 1'b0; expect_mc(0, 1'b1, "R7 spare feeds home XOR");
    expect_mc(2, 1'b0, "R7 spare not in steered sum");
    ext[0] = 1'b1; pol[0] = 1'b1; expect_mc(0, 1'b1, "R6 polarity constant alone (R9)");
    expect_mc(2, 1'b1, "R6 spare joins steered sum");
    st[0] = 2'd0; expect_mc(0, 1'b0, "R6 polarity inverts sum");

    // R8: each cluster, each code, one enabled term
    for (int c = 0; c < N_MC; c++)
      for (int code = 0; code < 4; code++) begin
        clear_cfg(); ext = '1; poff[c*PT_PER] = 1'b0; st[c] = code[1:0];
        for (int m = 0; m < N_MC; m++)
          expect_mc(m, m == (c + (code == 0 ? 0 : code == 1 ? 1 : code == 2 ? N_MC-1 : 2)) % N_MC,
                    "R8 steering");
      end

    // R10: all clusters into macrocell 0, one term at a time
    clear_cfg(); ext = '1; st[0] = 2'd0; st[1] = 2'd2; st[2] = 2'd3; st[3] = 2'd1;
    for (int mode = 0; mode < 2; mode++)
      for (int p = 0; p < N_PT; p++) begin
        poff = '1; poff[p] = 1'b0; asy = '0; asy[0] = mode[0];
        expect_mc(0, !(mode == 1 && (p == 2 || p == 3)), "R10 wide sum");
      end

    // Random phase: R9 and all others against the model
    for (int n = 0; n < 3000; n++) begin
      if (n % 8 == 0) begin
        for (int p = 0; p < N_PT; p++) begin
          lt[p] = sparse(); lc[p] = sparse();
          poff[p] = (($urandom % 4) == 0);
        end
        asy = N_MC'($urandom); ext = N_MC'($urandom); pol = N_MC'($urandom);
        for (int c = 0; c < N_MC; c++) st[c] = 2'($urandom);
      end
      din = {1'($urandom), $urandom};
      check_all("R9 random");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule